// File: doc/BRIEF.md
# Two-Axis Straight-Line Step Pulse Generator

This block drives two stepper axes, X and Y, so that the tool point travels along a straight line from where it stands to a commanded end point. A move begins with a one-cycle start strobe. The target is taken either as an absolute signed coordinate or as a signed offset from the present position. The block keeps the present position in its own registers, which reset clears to the origin. Steps are chosen by an integer error accumulator. The axis with the larger travel steps on every output slot. The other axis steps only when the accumulated error says the path has drifted half a unit or more off the ideal line.

Pulse slots are spaced by a base period given in clock cycles. When the constant-path-speed option is on, any slot in which both axes stepped is followed by a longer gap. That gap is the period times about 1.414, so that a diagonal step takes as long in path terms as a single-axis step. The direction outputs are set when the move is accepted. Each step output is a single-clock pulse. A busy flag covers the move, and a one-cycle done flag marks its end.

The controller has three named states. ST_IDLE waits for start. A start with a non-zero travel moves it to ST_SETUP. A zero-travel start pulses done and stays in ST_IDLE. ST_SETUP loads the accumulator and the interval timer, then moves unconditionally to ST_RUN. ST_RUN issues one slot each time the timer expires. It returns to ST_IDLE at the slot that issues the last major-axis step.

Top module: `lin_interp_pulse`

## Requirements
- R1: After reset, step_x, step_y, busy and done are 0, and the internal position is (0,0). An absolute move issued right after reset therefore travels exactly its target coordinates.
- R2: The travel is sampled at the clock edge that accepts start. With abs_mode=1 it is target minus the present position. With abs_mode=0 it is the target value itself. The present position is updated by every step issued.
- R3: A move issues exactly |dX| pulses on step_x and |dY| pulses on step_y. dir_x is 1 for positive X travel and 0 for negative X travel. dir_y follows the same rule for Y.
- R4: The major axis is the one with the larger |travel|, with X chosen on a tie. Every slot steps the major axis, and the minor axis steps only in slots where the major axis also steps. After k major steps and m minor steps, |2·(m·|dMaj| − k·|dMin|)| ≤ |dMaj|, which keeps the position within half a unit of the line.
- R5: The first step appears at the second rising edge after the edge that accepts start. The direction outputs take their new values at the accepting edge and do not change during the move.
- R6: Let P = max(base_period, 2), sampled at start. With const_spd=0 (sampled at start), consecutive steps are exactly P clocks apart, whether or not the slot was diagonal.
- R7: With const_spd=1, the gap after a slot in which both axes stepped is P + floor(53·P/128) clocks. After any other slot the gap is P.
- R8: Every step pulse is high for exactly one clock, and done is a one-clock pulse.
- R9: busy is 1 from the cycle after start is accepted until the cycle of the final step. In that cycle busy is 0 and done is 1, together with the final step pulse.
- R10: A start whose travel is zero on both axes gives done=1 in the cycle after start, with busy staying 0 and no step pulses.
- R11: A start strobe while a move is in progress is ignored. Step counts, directions and the stored position are those of the move in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a move; honoured only when idle |
| abs_mode | input | 1 | 1: target is an absolute coordinate; 0: target is a relative offset |
| const_spd | input | 1 | 1: stretch the gap after diagonal slots to hold path speed |
| tgt_x | input | CW (32) | Signed X target or offset |
| tgt_y | input | CW (32) | Signed Y target or offset |
| base_period | input | PW (16) | Slot spacing in clocks; values below 2 act as 2 |
| step_x | output | 1 | One-clock X step pulse |
| step_y | output | 1 | One-clock Y step pulse |
| dir_x | output | 1 | X direction, 1 = positive |
| dir_y | output | 1 | Y direction, 1 = positive |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-clock pulse at the end of a move |

## Verification
A corrupted error accumulator shows up at the first wrong minor decision. A minor pulse then appears one slot early or late, and the running deviation against the line exceeds half a unit within that same slot. A bad interval timer or a wrong stretch choice shows up as one gap that is off by at least one clock at the next step after a diagonal slot. A damaged position register or remaining-step count stays hidden during the move. It then shows as a wrong pulse total when done arrives, or, for the position, as wrong travel on the next absolute move. The bench therefore ends every scenario with an absolute move or a count check.

// File: rtl/lip_pkg.sv
`timescale 1ns/1ps
package lip_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_RUN   = 2'd2
    } lip_state_t;
endpackage

// File: rtl/lip_delta.sv
`timescale 1ns/1ps
// Travel for one axis: target minus present position, or the target as an offset.
module lip_delta #(
    parameter int CW = 32
) (
    input  logic signed [CW-1:0] target,
    input  logic signed [CW-1:0] current,
    input  logic                 abs_mode,
    output logic signed [CW:0]   delta,
    output logic                 zero
);
    always_comb begin
        if (abs_mode)
            delta = $signed({target[CW-1], target}) - $signed({current[CW-1], current});
        else
            delta = $signed({target[CW-1], target});
        zero = (delta == '0);
    end
endmodule

// File: rtl/lip_bres.sv
`timescale 1ns/1ps
// Integer error accumulator and remaining-slot counter.
module lip_bres #(
    parameter int MW = 33
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [MW-1:0] mag_maj,
    input  logic [MW-1:0] mag_min,
    input  logic          advance,
    output logic          minor_hit,
    output logic          last
);
    localparam int EW = MW + 2;

    logic signed [EW-1:0] err, inc_min, inc_both;
    logic [MW-1:0]        left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err      <= '0;
            inc_min  <= '0;
            inc_both <= '0;
            left     <= '0;
        end else if (load) begin
            err      <= $signed({1'b0, mag_min, 1'b0}) - $signed({2'b00, mag_maj});
            inc_min  <= $signed({1'b0, mag_min, 1'b0});
            inc_both <= $signed({1'b0, mag_min, 1'b0}) - $signed({1'b0, mag_maj, 1'b0});
            left     <= mag_maj;
        end else if (advance) begin
            err      <= err + (minor_hit ? inc_both : inc_min);
            left     <= left - 1'b1;
        end
    end

    assign minor_hit = !err[EW-1];
    assign last      = (left == MW'(1));

    // R4: never issue a slot once the major travel is used up
    a_r4_no_extra_slot: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (left != '0));
endmodule

// File: rtl/lip_interval.sv
`timescale 1ns/1ps
// Slot timer: base gap, or the stretched gap after a diagonal slot.
module lip_interval #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          reload,
    input  logic          stretch,
    input  logic [PW-1:0] period,
    output logic          expired
);
    localparam int TW = PW + 1;

    logic [TW-1:0]   eff, long_gap, timer;
    logic [TW+5:0]   prod;

    always_comb begin
        eff      = (period < PW'(2)) ? TW'(2) : {1'b0, period};
        prod     = {6'b0, eff} * (TW+6)'(53);
        long_gap = eff + TW'(prod >> 7);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            timer <= '0;
        else if (arm)
            timer <= '0;
        else if (reload)
            timer <= (stretch ? long_gap : eff) - 1'b1;
        else if (timer != '0)
            timer <= timer - 1'b1;
    end

    assign expired = (timer == '0);

    // R8: a reload always leaves at least one idle clock before the next slot
    a_r8_gap_two: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (timer != '0));
endmodule

// File: rtl/lin_interp_pulse.sv
`timescale 1ns/1ps
module lin_interp_pulse
    import lip_pkg::*;
#(
    parameter int CW = 32,
    parameter int PW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 abs_mode,
    input  logic                 const_spd,
    input  logic signed [CW-1:0] tgt_x,
    input  logic signed [CW-1:0] tgt_y,
    input  logic [PW-1:0]        base_period,
    output logic                 step_x,
    output logic                 step_y,
    output logic                 dir_x,
    output logic                 dir_y,
    output logic                 busy,
    output logic                 done
);
    localparam int MW = CW + 1;

    lip_state_t state, nxt;

    logic signed [CW-1:0] pos_x, pos_y;
    logic signed [MW-1:0] dlt_x, dlt_y, dx_q, dy_q;
    logic                 zx, zy;
    logic [MW-1:0]        mag_x, mag_y, mag_maj, mag_min;
    logic                 y_major, cs_q;
    logic [PW-1:0]        per_q;
    logic                 expired, minor_hit, last, arm, adv, take_x, take_y;

    lip_delta #(.CW(CW)) u_dx (.target(tgt_x), .current(pos_x), .abs_mode(abs_mode),
                               .delta(dlt_x), .zero(zx));
    lip_delta #(.CW(CW)) u_dy (.target(tgt_y), .current(pos_y), .abs_mode(abs_mode),
                               .delta(dlt_y), .zero(zy));

    always_comb begin
        mag_x   = dx_q[MW-1] ? MW'(-dx_q) : MW'(dx_q);
        mag_y   = dy_q[MW-1] ? MW'(-dy_q) : MW'(dy_q);
        y_major = (mag_y > mag_x);
        mag_maj = y_major ? mag_y : mag_x;
        mag_min = y_major ? mag_x : mag_y;
        arm     = (state == ST_SETUP);
        adv     = (state == ST_RUN) && expired;
        take_x  = adv && (y_major ? minor_hit : 1'b1);
        take_y  = adv && (y_major ? 1'b1 : minor_hit);
    end

    lip_bres #(.MW(MW)) u_bres (
        .clk(clk), .rst_n(rst_n), .load(arm), .mag_maj(mag_maj), .mag_min(mag_min),
        .advance(adv), .minor_hit(minor_hit), .last(last));

    lip_interval #(.PW(PW)) u_gap (
        .clk(clk), .rst_n(rst_n), .arm(arm), .reload(adv),
        .stretch(cs_q && minor_hit), .period(per_q), .expired(expired));

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start && !(zx && zy)) nxt = ST_SETUP;
            ST_SETUP: nxt = ST_RUN;
            ST_RUN:   if (adv && last) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and move registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_x <= 1'b0;
            step_y <= 1'b0;
            dir_x  <= 1'b0;
            dir_y  <= 1'b0;
            busy   <= 1'b0;
            done   <= 1'b0;
            pos_x  <= '0;
            pos_y  <= '0;
            dx_q   <= '0;
            dy_q   <= '0;
            cs_q   <= 1'b0;
            per_q  <= '0;
        end else begin
            step_x <= 1'b0;
            step_y <= 1'b0;
            done   <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    dx_q  <= dlt_x;
                    dy_q  <= dlt_y;
                    dir_x <= !dlt_x[MW-1];
                    dir_y <= !dlt_y[MW-1];
                    cs_q  <= const_spd;
                    per_q <= base_period;
                    if (zx && zy) done <= 1'b1;
                    else          busy <= 1'b1;
                end
                ST_SETUP: ;
                ST_RUN: if (adv) begin
                    step_x <= take_x;
                    step_y <= take_y;
                    if (take_x) pos_x <= dir_x ? pos_x + 1'b1 : pos_x - 1'b1;
                    if (take_y) pos_y <= dir_y ? pos_y + 1'b1 : pos_y - 1'b1;
                    if (last) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    a_r8_x_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        step_x |=> !step_x);
    a_r8_y_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        step_y |=> !step_y);
    a_r4_minor_with_major: assert property (@(posedge clk) disable iff (!rst_n)
        (step_x || step_y) |-> (y_major ? step_y : step_x));
    a_r5_dir_x_steady: assert property (@(posedge clk) disable iff (!rst_n)
        step_x |-> $stable(dir_x));
    a_r5_dir_y_steady: assert property (@(posedge clk) disable iff (!rst_n)
        step_y |-> $stable(dir_y));
    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r9_fall_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    a_r3_steps_in_move: assert property (@(posedge clk) disable iff (!rst_n)
        (step_x || step_y) |-> (busy || done));
endmodule

// File: tb/lin_interp_pulse_test.sv
`timescale 1ns/1ps
module lin_interp_pulse_test;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic               abs_mode = 1'b0;
    logic               const_spd = 1'b0;
    logic signed [31:0] tgt_x = '0;
    logic signed [31:0] tgt_y = '0;
    logic [15:0]        base_period = 16'd4;
    logic               step_x, step_y, dir_x, dir_y, busy, done;

    int     n_chk = 0;
    int     n_fail = 0;
    longint mx = 0;
    longint my = 0;

    always #2.5 clk = ~clk;

    lin_interp_pulse uut (
        .clk(clk), .rst_n(rst_n), .start(start), .abs_mode(abs_mode),
        .const_spd(const_spd), .tgt_x(tgt_x), .tgt_y(tgt_y),
        .base_period(base_period), .step_x(step_x), .step_y(step_y),
        .dir_x(dir_x), .dir_y(dir_y), .busy(busy), .done(done));

    function automatic longint labs(longint v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic chk(bit ok, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(!step_x && !step_y && !busy && !done, "R1 outputs idle in reset",
            {step_x, step_y, busy, done}, 0);
        rst_n = 1'b1;
        mx = 0;
        my = 0;
        @(negedge clk);
        chk(!step_x && !step_y && !busy && !done, "R1 outputs idle after reset",
            {step_x, step_y, busy, done}, 0);
    endtask

    task automatic run_move(longint tx, longint ty, bit am, bit cs, int per,
                            string tag, bit poke);
        longint dx = am ? tx - mx : tx;
        longint dy = am ? ty - my : ty;
        longint ax = labs(dx);
        longint ay = labs(dy);
        bit     ymaj = (ay > ax);
        longint dmaj = ymaj ? ay : ax;
        longint dmin = ymaj ? ax : ay;
        longint p = (per < 2) ? 2 : per;
        longint lp = p + (p * 53) / 128;
        longint sx = 0, sy = 0, gap_act = 0, gap_exp = 0;
        int     c = 1, prev = 1, first_c = 0;
        int     bad_gap = 0, bad_dev = 0, bad_busy = 0, bad_wide = 0, bad_dir = 0;
        bit     prev_diag = 1'b0, fin_ok = 1'b0;
        @(negedge clk);
        tgt_x = tx[31:0];
        tgt_y = ty[31:0];
        abs_mode = am;
        const_spd = cs;
        base_period = per[15:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (dx == 0 && dy == 0) begin
            chk(done == 1'b1, {tag, " R10 done one clock after start"}, done, 1);
            chk(!busy && !step_x && !step_y, {tag, " R10 no busy or step"},
                {busy, step_x, step_y}, 0);
            @(negedge clk);
            chk(!done && !busy && !step_x && !step_y, {tag, " R10 quiet afterwards"},
                {done, busy, step_x, step_y}, 0);
            return;
        end
        chk(busy == 1'b1, {tag, " R9 busy after start"}, busy, 1);
        if (dx != 0) chk(dir_x == (dx > 0), {tag, " R3 dir_x"}, dir_x, dx > 0);
        if (dy != 0) chk(dir_y == (dy > 0), {tag, " R3 dir_y"}, dir_y, dy > 0);
        while (c < 100000) begin
            @(negedge clk);
            c++;
            if (poke) begin
                start = (c == 4);
                if (c == 4) begin
                    tgt_x = tgt_x + 32'sd7;
                    tgt_y = tgt_y - 32'sd5;
                end
            end
            if ((dx != 0 && dir_x != (dx > 0)) || (dy != 0 && dir_y != (dy > 0))) bad_dir++;
            if (step_x || step_y) begin
                if (first_c == 0) first_c = c;
                else begin
                    if (c - prev == 1) bad_wide++;
                    if (c - prev != ((prev_diag && cs) ? lp : p)) begin
                        bad_gap++;
                        gap_act = c - prev;
                        gap_exp = (prev_diag && cs) ? lp : p;
                    end
                end
                if (step_x) sx++;
                if (step_y) sy++;
                if (ymaj ? (step_x && !step_y) : (step_y && !step_x)) bad_dev++;
                if (labs(2 * ((ymaj ? sx : sy) * dmaj - (ymaj ? sy : sx) * dmin)) > dmaj)
                    bad_dev++;
                prev_diag = step_x && step_y;
                prev = c;
            end
            if (done) begin
                fin_ok = (step_x || step_y) && !busy;
                break;
            end
            if (!busy) bad_busy++;
        end
        start = 1'b0;
        chk(fin_ok, {tag, " R9 done with final step, busy low"}, fin_ok, 1);
        chk(bad_busy == 0, {tag, " R9 busy held during move"}, bad_busy, 0);
        chk(first_c == 3, {tag, " R5 first step timing"}, first_c, 3);
        chk(bad_dir == 0, {tag, " R5 direction steady"}, bad_dir, 0);
        chk(sx == ax, {tag, " R3 x step count"}, sx, ax);
        chk(sy == ay, {tag, " R3 y step count"}, sy, ay);
        chk(bad_dev == 0, {tag, " R4 line deviation"}, bad_dev, 0);
        chk(bad_wide == 0, {tag, " R8 single-clock pulses"}, bad_wide, 0);
        chk(bad_gap == 0, {tag, cs ? " R7 stretched spacing" : " R6 spacing"},
            gap_act, gap_exp);
        @(negedge clk);
        chk(!done && !step_x && !step_y, {tag, " R8 done one clock"},
            {done, step_x, step_y}, 0);
        mx += dx;
        my += dy;
    endtask

    task automatic t_shallow();    run_move(13, 5, 0, 0, 4, "shallow", 0);        endtask
    task automatic t_steep();      run_move(-3, 17, 0, 0, 3, "steep", 0);         endtask
    task automatic t_one_axis();   run_move(0, -9, 0, 0, 2, "one-axis", 0);       endtask
    task automatic t_diag_off();   run_move(6, 6, 0, 0, 5, "diag R6", 0);         endtask
    task automatic t_diag_cs();    run_move(7, -7, 0, 1, 8, "diag R7", 0);        endtask
    task automatic t_mixed_cs();   run_move(10, 4, 0, 1, 100, "mixed R7", 0);     endtask
    task automatic t_abs();        run_move(-5, 20, 1, 0, 3, "R2 abs", 0);        endtask
    task automatic t_zero_rel();   run_move(0, 0, 0, 0, 4, "zero rel", 0);        endtask
    task automatic t_zero_abs();   run_move(mx, my, 1, 0, 4, "R2 zero abs", 0);   endtask
    task automatic t_min_per0();   run_move(5, 2, 0, 0, 0, "R6 period0", 0);      endtask
    task automatic t_min_per1();   run_move(4, -1, 0, 1, 1, "R7 period1", 0);     endtask
    task automatic t_busy_start(); run_move(20, 3, 0, 0, 3, "R11 busy start", 1); endtask
    task automatic t_home();       run_move(0, 0, 1, 1, 6, "R11 R2 home", 0);     endtask
    task automatic t_after_reset(); run_move(2, -4, 1, 0, 2, "R1 R2 abs after reset", 0); endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_shallow();
        t_steep();
        t_one_axis();
        t_diag_off();
        t_diag_cs();
        t_mixed_cs();
        t_abs();
        t_zero_rel();
        t_zero_abs();
        t_min_per0();
        t_min_per1();
        t_busy_start();
        t_home();
        t_shallow();
        t_reset();
        t_after_reset();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule